// File: doc/BRIEF.md
# Sample Buffer with Half-Full Transfer Request

This block sits between an analog-to-digital converter and a host bus. Converted samples arrive on a write stream and are stored in a first-in, first-out buffer of 4096 16-bit words. Once half of the buffer is occupied, the block raises a level-sensitive transfer request. The host answers by draining the buffer, either one word at a time or as a block of back-to-back reads. The converter keeps writing into the free half of the buffer while the host services the request.

Both data paths use valid/ready handshakes. On the write side, a word is taken on every cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only when the buffer is full. The converter cannot stall, so if it presents a word while `in_ready` is low, that word is discarded and the sticky `overrun` flag is set.

On the read side, `out_valid` shows that stored data exists, and a pulse on `out_ready` pops one word. The popped word appears on `out_data` one cycle after the handshake and stays there until the next pop. A pop requested while the buffer is empty changes nothing except that it sets the sticky `underflow` flag. The host clears both error flags with `err_clr`.

Top module: `sample_block_buffer`

## Requirements
- R1: The buffer holds up to 4096 words of 16 bits and returns them in the order they were accepted.
- R2: `in_ready` is low exactly when `full` is high; a word is stored only on a cycle with `in_valid` and `in_ready` both high.
- R3: `xfer_req` is high whenever `level` is 2048 or more and low whenever `level` is 2047 or less.
- R4: Writes continue to be accepted while `xfer_req` is high, until the buffer becomes full.
- R5: A pop (`out_ready` high while `out_valid` is high) places the oldest word on `out_data` on the next cycle. Pops may occur on every consecutive cycle, so a block of 2048 reads drains in 2048 cycles.
- R6: A word presented while `full` is high is discarded and sets `overrun`. `overrun` stays high until a cycle with `err_clr` high and no new overrun.
- R7: `out_ready` while `empty` is high leaves `out_data` and `level` unchanged and sets `underflow`. `underflow` stays high until cleared by `err_clr`, in the same way as `overrun`.
- R8: A push and a pop in the same cycle leave the 13-bit `level` unchanged.
- R9: A synchronous reset (`rst` high at a clock edge) empties the buffer and clears `level`, `xfer_req`, `overrun` and `underflow`.
- R10: `full` is high exactly when `level` is 4096; `empty` is high exactly when `level` is 0; `out_valid` equals not `empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Converter presents a sample |
| in_ready | output | 1 | Buffer can accept a sample (not full) |
| in_data | input | 16 | Sample word |
| out_valid | output | 1 | At least one word stored |
| out_ready | input | 1 | Host read strobe (pop) |
| out_data | output | 16 | Last popped word, updated the cycle after a pop |
| err_clr | input | 1 | Clears the sticky error flags |
| xfer_req | output | 1 | Block transfer request, level at or above half |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level equals capacity |
| level | output | 13 | Number of stored words |
| overrun | output | 1 | Sticky: a sample was dropped while full |
| underflow | output | 1 | Sticky: a pop was requested while empty |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 16-bit data. The exact threshold of 2048 and the full point of 4096 therefore appear within a few thousand cycles. The bench observes the request at the cycle it should rise and the cycle it should fall, and it checks that `in_ready` drops at full. It also runs a block drain of 2048 words interleaved with concurrent writes, and then checks that the dropped overrun word never appears in the read sequence.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SBUF_DATA_W = 16;
  localparam int unsigned SBUF_ADDR_W = 12;

  // Threshold at which a block transfer is requested: half of capacity.
  function automatic int unsigned sbuf_half(input int unsigned addr_w);
    return (32'd1 << addr_w) >> 1;
  endfunction
endpackage

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Output register only moves on a pop, so it holds the last word otherwise.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W:0]   fill,
  output logic              is_full,
  output logic              is_empty
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(1) << ADDR_W;

  assign is_full  = (fill == CAP);
  assign is_empty = (fill == '0);
  assign push_ok  = push_req && !is_full;
  assign pop_ok   = pop_req && !is_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_flags.sv
module sbuf_flags #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            drop_evt,
  input  logic            under_evt,
  input  logic [ADDR_W:0] fill,
  output logic            req,
  output logic            ovr,
  output logic            und
);
  import sbuf_pkg::*;
  localparam logic [ADDR_W:0] HALF = (ADDR_W+1)'(sbuf_half(ADDR_W));

  assign req = (fill >= HALF);

  // New events take priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr <= 1'b0;
      und <= 1'b0;
    end else begin
      if (drop_evt)  ovr <= 1'b1;
      else if (clr)  ovr <= 1'b0;
      if (under_evt) und <= 1'b1;
      else if (clr)  und <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_block_buffer.sv
module sample_block_buffer #(
  parameter int unsigned DATA_W = sbuf_pkg::SBUF_DATA_W,
  parameter int unsigned ADDR_W = sbuf_pkg::SBUF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              err_clr,
  output logic              xfer_req,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W:0]   level,
  output logic              overrun,
  output logic              underflow
);
  logic              push_ok, pop_ok;
  logic [ADDR_W-1:0] wptr, rptr;

  sbuf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(in_valid), .pop_req(out_ready),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .fill(level),
    .is_full(full), .is_empty(empty)
  );

  sbuf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(push_ok), .waddr(wptr), .wdata(in_data),
    .re(pop_ok), .raddr(rptr), .rdata(out_data)
  );

  sbuf_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst(rst), .clr(err_clr),
    .drop_evt(in_valid && full), .under_evt(out_ready && empty),
    .fill(level), .req(xfer_req), .ovr(overrun), .und(underflow)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              xfer_req,
  input logic              empty,
  input logic              full,
  input logic [ADDR_W:0]   level,
  input logic              overrun,
  input logic              underflow
);
  localparam logic [ADDR_W:0] CAP  = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF = CAP >> 1;

  a_r10_level_bound: assert property (@(posedge clk) disable iff (rst) level <= CAP);
  a_r2_no_ready_when_full: assert property (@(posedge clk) disable iff (rst) full |-> !in_ready);
  a_r3_req_rises_at_half: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_req) |-> level == HALF);
  a_r3_req_falls_below_half: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_req) |-> level == HALF - 1'b1);
  a_r6_drop_sets_overrun: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full) |=> overrun);
  a_r7_empty_pop_harmless: assert property (@(posedge clk) disable iff (rst)
    (out_ready && empty && !in_valid) |=> (underflow && $stable(out_data) && level == '0));
  a_r8_push_pop_level_held: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_ready && out_valid) |=> $stable(level));
  a_r10_valid_tracks_empty: assert property (@(posedge clk) disable iff (rst)
    out_valid != empty);
endmodule

bind sample_block_buffer sbuf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sbuf_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .xfer_req(xfer_req), .empty(empty), .full(full), .level(level),
  .overrun(overrun), .underflow(underflow)
);

// File: tb/test_sample_block_buffer.sv
module test_sample_block_buffer;
  logic        clk = 1'b0;
  logic        rst, in_valid, out_ready, err_clr;
  logic [15:0] in_data;
  logic        in_ready, out_valid, xfer_req, empty, full, overrun, underflow;
  logic [15:0] out_data;
  logic [12:0] level;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sample_block_buffer i_sample_block_buffer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err_clr(err_clr),
    .xfer_req(xfer_req), .empty(empty), .full(full), .level(level),
    .overrun(overrun), .underflow(underflow)
  );

  // Vector: push(1) data(16) pop(1) exp_level(13) chk_data(1) exp_data(16)
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 16'hA001, 1'b0, 13'd1, 1'b0, 16'h0000},
    {1'b1, 16'hA002, 1'b0, 13'd2, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 13'd1, 1'b1, 16'hA001},
    {1'b1, 16'hA003, 1'b1, 13'd1, 1'b1, 16'hA002},
    {1'b0, 16'h0000, 1'b1, 13'd0, 1'b1, 16'hA003},
    {1'b1, 16'hA004, 1'b0, 13'd1, 1'b0, 16'h0000},
    {1'b1, 16'hA005, 1'b1, 13'd1, 1'b1, 16'hA004},
    {1'b0, 16'h0000, 1'b1, 13'd0, 1'b1, 16'hA005}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, clock once, return at the following negedge.
  task automatic cyc(input logic w, input logic [15:0] d, input logic r);
    in_valid = w; in_data = d; out_ready = r;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; err_clr = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9/R10: reset state
    chk("R9 level after reset", 32'(level), 0);
    chk("R10 empty after reset", 32'(empty), 1);
    chk("R9 req after reset", 32'(xfer_req), 0);
    chk("R2 ready after reset", 32'(in_ready), 1);

    // Table walk: R1 order, R5 read latency, R8 simultaneous push/pop
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][47], VEC[i][46:31], VEC[i][30]);
      chk("R8 level per vector", 32'(level), 32'(VEC[i][29:17]));
      if (VEC[i][16]) chk("R5 popped data", 32'(out_data), 32'(VEC[i][15:0]));
    end

    // R7: pop while empty
    cyc(1'b0, 16'h0, 1'b1);
    chk("R7 data held on empty pop", 32'(out_data), 32'hA005);
    chk("R7 level unchanged", 32'(level), 0);
    chk("R7 underflow set", 32'(underflow), 1);
    err_clr = 1'b1; cyc(1'b0, 16'h0, 1'b0); err_clr = 1'b0;
    chk("R7 underflow cleared", 32'(underflow), 0);

    // R3/R4: fill across the threshold to full
    for (int i = 0; i < 2047; i++) cyc(1'b1, 16'(i), 1'b0);
    chk("R3 req low at 2047", 32'(xfer_req), 0);
    cyc(1'b1, 16'd2047, 1'b0);
    chk("R3 req high at 2048", 32'(xfer_req), 1);
    for (int i = 2048; i < 4096; i++) cyc(1'b1, 16'(i), 1'b0);
    chk("R4 writes accepted while requesting", 32'(level), 4096);
    chk("R10 full at capacity", 32'(full), 1);
    chk("R2 not ready when full", 32'(in_ready), 0);

    // R6: drop while full
    cyc(1'b1, 16'hDEAD, 1'b0);
    chk("R6 level unchanged on drop", 32'(level), 4096);
    chk("R6 overrun set", 32'(overrun), 1);

    // R5: block drain of half capacity, back to back
    for (int i = 0; i < 2048; i++) begin
      cyc(1'b0, 16'h0, 1'b1);
      chk("R5 block drain data", 32'(out_data), 32'(i));
    end
    chk("R3 req held at 2048", 32'(xfer_req), 1);
    // R4/R8: concurrent write during draining
    for (int k = 0; k < 100; k++) begin
      cyc(1'b1, 16'h8000 + 16'(k), 1'b1);
      chk("R8 concurrent data", 32'(out_data), 32'(2048 + k));
    end
    chk("R8 level held by concurrent ops", 32'(level), 2048);
    cyc(1'b0, 16'h0, 1'b1);
    chk("R3 req low below half", 32'(xfer_req), 0);
    chk("R6 overrun still sticky", 32'(overrun), 1);
    for (int i = 2149; i < 4096; i++) begin
      cyc(1'b0, 16'h0, 1'b1);
      if (i == 4095) chk("R1 last original word", 32'(out_data), 4095);
    end
    cyc(1'b0, 16'h0, 1'b1);
    chk("R6 dropped word absent", 32'(out_data), 32'h8000);
    for (int k = 1; k < 100; k++) cyc(1'b0, 16'h0, 1'b1);
    chk("R1 final word order", 32'(out_data), 32'h8063);
    chk("R10 empty after drain", 32'(empty), 1);
    err_clr = 1'b1; cyc(1'b0, 16'h0, 1'b0); err_clr = 1'b0;
    chk("R6 overrun cleared", 32'(overrun), 0);

    // R9: reset with contents
    for (int i = 0; i < 5; i++) cyc(1'b1, 16'(i), 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    rst = 1'b1; cyc(1'b0, 16'h0, 1'b0); rst = 1'b0;
    chk("R9 level cleared", 32'(level), 0);
    chk("R9 empty set", 32'(empty), 1);
    chk("R9 underflow cleared", 32'(underflow), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule